// File: doc/BRIEF.md
# Color Channel Sampling Sequencer

This block drives the select lines of a three-input sample multiplexer that sits in front of one shared converter. A pixel-start strobe begins each pixel, and a one-cycle converter tick marks every edge on which the converter takes a sample. For each tick the block gives a 2-bit channel index, a valid flag for that sample, and a marker on the first sample of the pixel.

The block reads three configuration inputs: a channel-count bit, an order bit and a one-hot single-channel field. It latches them only when a pixel strobe arrives. In three-channel mode it steps through red, green and blue, forward or reversed, and each strobe restarts the walk at the first channel of the order. In one-channel mode it stays on the channel picked by the one-hot field. An illegal one-hot field falls back to red and sets a sticky error flag.

Top module: `chan_seq_top`

## Requirements
- R1: After reset `chan_idx` is 0, `samp_valid`, `pix_first` and `cfg_err` are low, and converter ticks before the first pixel strobe give no valid sample.
- R2: With `cfg_three`=1 and `cfg_fwd`=1 latched, the first three ticks of a pixel give valid samples on index 0 (red), 1 (green) and 2 (blue), in that order.
- R3: With `cfg_three`=1 and `cfg_fwd`=0 latched, the first three ticks give index 2, 1, 0.
- R4: The cycle after a pixel strobe, `chan_idx` shows the first channel of the newly latched order and `samp_valid` is low, even when the strobe arrives partway through a pixel.
- R5: With `cfg_three`=0, `cfg_pick` bit 0 selects red (0), bit 1 green (1) and bit 2 blue (2). Only the first tick of the pixel gives a valid sample.
- R6: Ticks beyond the pixel's allowance (three or one) give `samp_valid` low and leave `chan_idx` on the last sampled channel.
- R7: In one-channel mode, a `cfg_pick` value that is zero or has more than one bit set selects red and sets `cfg_err`. `cfg_err` then stays high until reset. Legal values never set it.
- R8: A change of the configuration inputs between strobes has no effect on the current pixel's sequence.
- R9: `pix_first` is high exactly with the first valid sample of a pixel.
- R10: A strobe and a tick in the same cycle act as a strobe only, and produce no valid sample.
- R11: `chan_idx` never shows 3.
- R12: Outputs change one clock after the strobe or tick that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_strobe | input | 1 | One-cycle pixel-start pulse; latches configuration |
| conv_tick | input | 1 | One-cycle pulse per converter sampling edge |
| cfg_three | input | 1 | 1: three channels per pixel, 0: one channel |
| cfg_fwd | input | 1 | 1: red-green-blue order, 0: blue-green-red |
| cfg_pick | input | 3 | One-hot single channel: bit0 red, bit1 green, bit2 blue |
| chan_idx | output | 2 | Multiplexer channel index (0 red, 1 green, 2 blue) |
| samp_valid | output | 1 | High for one cycle per accepted converter sample |
| pix_first | output | 1 | High with the first valid sample of a pixel |
| cfg_err | output | 1 | Sticky flag for an illegal single-channel field |

## Verification
The sequencer is driven with forward and reversed three-channel pixels, and with each of the three legal one-hot picks, so that any mapping slip between order, pick bit and index shows up as a wrong channel value. Extra ticks past the allowance show whether the step counter saturates or wraps. A strobe partway through a pixel, and a strobe together with a tick, show whether restart has priority. A configuration change without a strobe, followed by zero and two-bit picks, tells the latching point apart from live decoding and checks that the error flag stays set.

// File: rtl/chan_seq_pkg.sv
package chan_seq_pkg;
  typedef logic [1:0] chan_idx_t;

  localparam chan_idx_t CH_RED = 2'd0;
  localparam chan_idx_t CH_GRN = 2'd1;
  localparam chan_idx_t CH_BLU = 2'd2;

  // One-hot pick to channel index; illegal patterns fall back to red
  function automatic chan_idx_t pick_to_chan(input logic [2:0] pick);
    case (pick)
      3'b001:  return CH_RED;
      3'b010:  return CH_GRN;
      3'b100:  return CH_BLU;
      default: return CH_RED;
    endcase
  endfunction

  function automatic logic pick_illegal(input logic [2:0] pick);
    return !(pick == 3'b001 || pick == 3'b010 || pick == 3'b100);
  endfunction

  // Channel for a given step of the pixel
  function automatic chan_idx_t chan_for_step(input logic three, input logic fwd,
                                              input chan_idx_t single, input int step,
                                              input int last);
    if (!three) return single;
    if (fwd)    return chan_idx_t'(step);
    return chan_idx_t'(last - step);
  endfunction
endpackage

// File: rtl/chan_seq_cfg.sv
module chan_seq_cfg
  import chan_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       three_in,
  input  logic       fwd_in,
  input  logic [2:0] pick_in,
  output logic       three_q,
  output logic       fwd_q,
  output chan_idx_t  single_q,
  output logic       err_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      three_q  <= 1'b1;
      fwd_q    <= 1'b1;
      single_q <= CH_RED;
      err_q    <= 1'b0;
    end else if (load) begin
      three_q  <= three_in;
      fwd_q    <= fwd_in;
      single_q <= pick_to_chan(pick_in);
      if (!three_in && pick_illegal(pick_in)) err_q <= 1'b1;
    end
  end
endmodule

// File: rtl/chan_seq_step.sv
module chan_seq_step #(
  parameter int NUM_CH = 3,
  localparam int CNT_W = $clog2(NUM_CH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             advance,
  input  logic             three,
  output logic [CNT_W-1:0] step_q,
  output logic             avail
);
  logic [CNT_W-1:0] limit;

  assign limit = three ? CNT_W'(NUM_CH) : CNT_W'(1);
  assign avail = (step_q < limit);

  always_ff @(posedge clk) begin
    if (rst)
      step_q <= CNT_W'(NUM_CH);  // exhausted until first strobe
    else if (restart)
      step_q <= '0;
    else if (advance && avail)
      step_q <= step_q + CNT_W'(1);
  end
endmodule

// File: rtl/chan_seq_top.sv
module chan_seq_top
  import chan_seq_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pix_strobe,
  input  logic       conv_tick,
  input  logic       cfg_three,
  input  logic       cfg_fwd,
  input  logic [2:0] cfg_pick,
  output logic [1:0] chan_idx,
  output logic       samp_valid,
  output logic       pix_first,
  output logic       cfg_err
);
  localparam int CNT_W = $clog2(NUM_CH + 1);
  localparam int LAST  = NUM_CH - 1;

  logic             three_q, fwd_q, avail;
  chan_idx_t        single_q;
  logic [CNT_W-1:0] step_q;

  chan_seq_cfg u_cfg (
    .clk(clk), .rst(rst), .load(pix_strobe),
    .three_in(cfg_three), .fwd_in(cfg_fwd), .pick_in(cfg_pick),
    .three_q(three_q), .fwd_q(fwd_q), .single_q(single_q), .err_q(cfg_err)
  );

  chan_seq_step #(.NUM_CH(NUM_CH)) u_step (
    .clk(clk), .rst(rst), .restart(pix_strobe), .advance(conv_tick),
    .three(three_q), .step_q(step_q), .avail(avail)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_idx   <= CH_RED;
      samp_valid <= 1'b0;
      pix_first  <= 1'b0;
    end else if (pix_strobe) begin
      chan_idx   <= chan_for_step(cfg_three, cfg_fwd, pick_to_chan(cfg_pick), 0, LAST);
      samp_valid <= 1'b0;
      pix_first  <= 1'b0;
    end else if (conv_tick && avail) begin
      chan_idx   <= chan_for_step(three_q, fwd_q, single_q, int'(step_q), LAST);
      samp_valid <= 1'b1;
      pix_first  <= (step_q == '0);
    end else begin
      samp_valid <= 1'b0;
      pix_first  <= 1'b0;
    end
  end
endmodule

// File: rtl/chan_seq_chk.sv
module chan_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       pix_strobe,
  input logic       conv_tick,
  input logic [1:0] chan_idx,
  input logic       samp_valid,
  input logic       pix_first,
  input logic       cfg_err
);
  // R11
  idx_range_chk: assert property (@(posedge clk) disable iff (rst) chan_idx != 2'd3);

  // R9
  first_valid_chk: assert property (@(posedge clk) disable iff (rst) pix_first |-> samp_valid);

  // R10
  strobe_quiet_chk: assert property (@(posedge clk) disable iff (rst) pix_strobe |=> !samp_valid);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst) cfg_err |=> cfg_err);

  // R6
  chan_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pix_strobe |=> (samp_valid || $stable(chan_idx)));

  // R12
  tick_needed_chk: assert property (@(posedge clk) disable iff (rst) !conv_tick |=> !samp_valid);
endmodule

bind chan_seq_top chan_seq_chk u_chk (
  .clk(clk), .rst(rst), .pix_strobe(pix_strobe), .conv_tick(conv_tick),
  .chan_idx(chan_idx), .samp_valid(samp_valid), .pix_first(pix_first), .cfg_err(cfg_err)
);

// File: tb/sim_chan_seq_top.sv
`timescale 1ns/1ps
module sim_chan_seq_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pix_strobe = 1'b0, conv_tick = 1'b0;
  logic       cfg_three = 1'b1, cfg_fwd = 1'b1;
  logic [2:0] cfg_pick = 3'b001;
  logic [1:0] chan_idx;
  logic       samp_valid, pix_first, cfg_err;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  chan_seq_top u0 (
    .clk(clk), .rst(rst), .pix_strobe(pix_strobe), .conv_tick(conv_tick),
    .cfg_three(cfg_three), .cfg_fwd(cfg_fwd), .cfg_pick(cfg_pick),
    .chan_idx(chan_idx), .samp_valid(samp_valid), .pix_first(pix_first), .cfg_err(cfg_err)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic strobe(logic three, logic fwd, logic [2:0] pick);
    @(negedge clk);
    cfg_three = three; cfg_fwd = fwd; cfg_pick = pick; pix_strobe = 1'b1;
    @(negedge clk);
    pix_strobe = 1'b0;
    chk("R4 valid low after strobe", samp_valid, 0);
  endtask

  task automatic tick(string tag, int exp_valid, int exp_chan, int exp_first);
    @(negedge clk);
    conv_tick = 1'b1;
    @(negedge clk);
    conv_tick = 1'b0;
    chk({tag, " valid"}, samp_valid, exp_valid);
    chk({tag, " chan"}, chan_idx, exp_chan);
    chk({tag, " first"}, pix_first, exp_first);
    chk("R11 idx not 3", int'(chan_idx == 2'd3), 0);
  endtask

  task automatic t_reset();
    chk("R1 chan", chan_idx, 0);
    chk("R1 valid", samp_valid, 0);
    chk("R1 first", pix_first, 0);
    chk("R1 err", cfg_err, 0);
    tick("R1 tick before strobe", 0, 0, 0);
  endtask

  task automatic t_forward();
    strobe(1'b1, 1'b1, 3'b001);
    chk("R4 first chan fwd", chan_idx, 0);
    tick("R2 s0", 1, 0, 1);
    tick("R2 s1", 1, 1, 0);
    tick("R2 s2", 1, 2, 0);
    tick("R6 extra", 0, 2, 0);
    tick("R6 extra2", 0, 2, 0);
  endtask

  task automatic t_reverse();
    strobe(1'b1, 1'b0, 3'b001);
    chk("R4 first chan rev", chan_idx, 2);
    tick("R3 s0", 1, 2, 1);
    tick("R3 s1", 1, 1, 0);
    tick("R3 s2", 1, 0, 0);
    tick("R6 extra rev", 0, 0, 0);
  endtask

  task automatic t_restart();
    strobe(1'b1, 1'b1, 3'b001);
    tick("R2 r0", 1, 0, 1);
    tick("R2 r1", 1, 1, 0);
    strobe(1'b1, 1'b0, 3'b001);
    chk("R4 restart chan", chan_idx, 2);
    tick("R4 restart s0", 1, 2, 1);
    tick("R4 restart s1", 1, 1, 0);
  endtask

  task automatic t_single();
    strobe(1'b0, 1'b1, 3'b001);
    tick("R5 red", 1, 0, 1);
    tick("R5 red extra", 0, 0, 0);
    strobe(1'b0, 1'b1, 3'b010);
    chk("R5 green preset", chan_idx, 1);
    tick("R5 green", 1, 1, 1);
    tick("R5 green extra", 0, 1, 0);
    strobe(1'b0, 1'b0, 3'b100);
    tick("R5 blue", 1, 2, 1);
    tick("R5 blue extra", 0, 2, 0);
    chk("R7 no err on legal pick", cfg_err, 0);
  endtask

  task automatic t_cfg_change();
    strobe(1'b1, 1'b1, 3'b001);
    tick("R8 s0", 1, 0, 1);
    @(negedge clk);
    cfg_three = 1'b0; cfg_fwd = 1'b0; cfg_pick = 3'b100;
    tick("R8 s1", 1, 1, 0);
    tick("R8 s2", 1, 2, 0);
    chk("R8 no err without strobe", cfg_err, 0);
  endtask

  task automatic t_collide();
    strobe(1'b1, 1'b1, 3'b001);
    tick("R10 pre", 1, 0, 1);
    @(negedge clk);
    cfg_three = 1'b1; cfg_fwd = 1'b0; pix_strobe = 1'b1; conv_tick = 1'b1;
    @(negedge clk);
    pix_strobe = 1'b0; conv_tick = 1'b0;
    chk("R10 no valid", samp_valid, 0);
    chk("R10 chan preset", chan_idx, 2);
    tick("R10 after s0", 1, 2, 1);
  endtask

  task automatic t_error();
    strobe(1'b0, 1'b1, 3'b000);
    chk("R7 err on zero pick", cfg_err, 1);
    tick("R7 zero pick red", 1, 0, 1);
    strobe(1'b0, 1'b1, 3'b110);
    tick("R7 multi pick red", 1, 0, 1);
    strobe(1'b0, 1'b1, 3'b010);
    chk("R7 err sticky", cfg_err, 1);
    tick("R7 legal after err", 1, 1, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_forward();
    t_reverse();
    t_restart();
    t_single();
    t_cfg_change();
    t_collide();
    t_error();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule